// File: doc/BRIEF.md
# PWM Divider Parameter Solver

This unit turns a requested PWM period, given as a count of source-clock cycles, into the three numbers a 16-bit PWM channel needs: a power-of-two clock divider exponent, an 8-bit linear prescaler, and the period count to load into the channel counter. The overall scale applied to the source clock is 1 / (2^div_m * (prescale + 1)). The power-of-two exponent is kept as small as possible first, and the prescaler is kept as small as possible second. Both come from closed-form arithmetic with no search loop.

The exponent is the position of the most significant set bit of the request divided by one fixed constant. The prescaler is one constant division of the shifted request. The period count is the shifted request divided by the prescaler ratio. These three steps are split over a short pipeline. A valid/ready handshake sits at each end, so a controller can feed requests back to back and stall on the result side without losing any. A parameter removes the two internal registers and leaves a single-register variant.

Top module: `pwm_div_solver`

## Requirements
- R1: With default widths, the divider constant is D = 255*65537 + 2*65536 + 1 = 16843008. rsp_div_m is the 1-based index of the highest set bit of floor(req_cycles / D), and it is 0 when that quotient is 0.
- R2: Let S = req_cycles >> rsp_div_m. rsp_prescale is 0 when S <= 65536, and floor((S - 65536) / 65537) otherwise.
- R3: rsp_div_m never exceeds DIVM_MAX. When the exponent from R1 would exceed it, rsp_div_m is DIVM_MAX and rsp_prescale is 255.
- R4: rsp_period is floor(S / (rsp_prescale + 1)), limited to 65535.
- R5: A request of zero cycles gives rsp_div_m = 0, rsp_prescale = 0 and rsp_period = 0.
- R6: While rsp_valid is high and rsp_ready is low, rsp_valid stays high and all result fields stay unchanged. rsp_valid falls only after a cycle in which rsp_ready was high.
- R7: Results leave in the order the requests were accepted. When rsp_ready is held high, a result is valid after three rising edges when MID_REGS = 1, or after one edge when MID_REGS = 0. The accepting edge counts as the first of these edges.
- R8: With rsp_ready held low, the unit accepts three requests when MID_REGS = 1, or one request when MID_REGS = 0. It then holds req_ready low, and no accepted request is lost.
- R9: During and directly after reset, rsp_valid is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when also valid |
| req_cycles | input | CYC_W | Requested period in source-clock cycles |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Downstream takes the result |
| rsp_div_m | output | DM_W | Power-of-two divider exponent |
| rsp_prescale | output | PSC_W | Linear prescaler value (ratio minus one) |
| rsp_period | output | CNT_W | Period count for the channel counter |

## Verification
In the registered configuration, a request accepted at one rising edge produces a result that is visible after the second edge that follows it. In the single-register variant, the result is visible straight after the accepting edge. A latency phase drives one request into both instances at the same time. It then samples each output at the falling edge of every following cycle, and expects rsp_valid high only in the cycle given by R7. The streaming phases drive inputs at the falling edge and then wait one time step for the handshake signals to settle. They log an acceptance or a consumption against the edge about to come, which keeps each expected result in a queue in the exact order the design must return it. A stall seen in one cycle is compared against the outputs one cycle later.

// File: rtl/pwmdiv_pkg.sv
package pwmdiv_pkg;

   // 1-based index of the highest set bit, 0 for a zero operand
   function automatic int top_bit_pos(input logic [63:0] v);
      int r;
      r = 0;
      for (int i = 0; i < 64; i++) begin
         if (v[i]) r = i + 1;
      end
      return r;
   endfunction

   // Threshold that makes the exponent search a single division:
   // max_prescale * (span + 1) + 2 * span + 1
   function automatic logic [63:0] exp_threshold(input int cnt_w, input int psc_w);
      logic [63:0] span;
      logic [63:0] kmax;
      span = 64'd1 << cnt_w;
      kmax = (64'd1 << psc_w) - 64'd1;
      return kmax * (span + 64'd1) + 64'd2 * span + 64'd1;
   endfunction

endpackage

// File: rtl/pwmdiv_slot.sv
module pwmdiv_slot #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);

   assign in_ready = !out_valid || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (in_ready) begin
         out_valid <= in_valid;
         if (in_valid) out_data <= in_data;
      end
   end

endmodule

// File: rtl/pwmdiv_range.sv
module pwmdiv_range
   import pwmdiv_pkg::*;
#(
   parameter int CYC_W    = 32,
   parameter int CNT_W    = 16,
   parameter int PSC_W    = 8,
   parameter int DIVM_MAX = 8,
   parameter int DM_W     = 4
) (
   input  logic [CYC_W-1:0] cycles,
   output logic [DM_W-1:0]  div_m,
   output logic             sat,
   output logic [CYC_W-1:0] scaled
);

   localparam logic [63:0] LIMIT = exp_threshold(CNT_W, PSC_W);

   logic [63:0] quot;
   int          msb;

   always_comb begin
      quot   = 64'(cycles) / LIMIT;
      msb    = top_bit_pos(quot);
      sat    = msb > DIVM_MAX;
      div_m  = sat ? DM_W'(DIVM_MAX) : DM_W'(msb);
      scaled = cycles >> div_m;
   end

endmodule

// File: rtl/pwmdiv_prescale.sv
module pwmdiv_prescale #(
   parameter int CYC_W = 32,
   parameter int CNT_W = 16,
   parameter int PSC_W = 8
) (
   input  logic             sat,
   input  logic [CYC_W-1:0] scaled,
   output logic [PSC_W-1:0] prescale
);

   localparam logic [63:0] SPAN = 64'd1 << CNT_W;
   localparam logic [63:0] STEP = SPAN + 64'd1;
   localparam logic [63:0] KMAX = (64'd1 << PSC_W) - 64'd1;

   logic [63:0] wide;
   logic [63:0] kq;

   always_comb begin
      wide = 64'(scaled);
      kq   = (wide <= SPAN) ? 64'd0 : (wide - SPAN) / STEP;
      if (sat || kq > KMAX) prescale = PSC_W'(KMAX);
      else                  prescale = kq[PSC_W-1:0];
   end

endmodule

// File: rtl/pwmdiv_count.sv
module pwmdiv_count #(
   parameter int CYC_W = 32,
   parameter int CNT_W = 16,
   parameter int PSC_W = 8
) (
   input  logic [CYC_W-1:0] scaled,
   input  logic [PSC_W-1:0] prescale,
   output logic [CNT_W-1:0] period
);

   localparam logic [63:0] TOP = (64'd1 << CNT_W) - 64'd1;

   logic [63:0] quot;

   always_comb begin
      quot   = 64'(scaled) / (64'(prescale) + 64'd1);
      period = (quot > TOP) ? CNT_W'(TOP) : quot[CNT_W-1:0];
   end

endmodule

// File: rtl/pwm_div_solver.sv
module pwm_div_solver #(
   parameter int CYC_W    = 32,
   parameter int CNT_W    = 16,
   parameter int PSC_W    = 8,
   parameter int DIVM_MAX = 8,
   parameter bit MID_REGS = 1'b1,
   localparam int DM_W    = $clog2(DIVM_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [CYC_W-1:0] req_cycles,
   output logic             rsp_valid,
   input  logic             rsp_ready,
   output logic [DM_W-1:0]  rsp_div_m,
   output logic [PSC_W-1:0] rsp_prescale,
   output logic [CNT_W-1:0] rsp_period
);

   localparam int WA = 1 + DM_W + CYC_W;
   localparam int WB = DM_W + CYC_W + PSC_W;
   localparam int WO = DM_W + PSC_W + CNT_W;

   // elaboration-time parameter checks
   if (CNT_W < 2 || CNT_W > 30) begin : g_bad_cnt
      $error("pwm_div_solver: CNT_W out of range");
   end
   if (PSC_W < 1 || PSC_W > 16) begin : g_bad_psc
      $error("pwm_div_solver: PSC_W out of range");
   end
   if (CYC_W > 63 || CYC_W < CNT_W + 1) begin : g_bad_cyc
      $error("pwm_div_solver: CYC_W out of range");
   end
   if (DIVM_MAX < 1 || DIVM_MAX >= CYC_W) begin : g_bad_dm
      $error("pwm_div_solver: DIVM_MAX out of range");
   end

   // stage 1: exponent and shifted count
   logic [DM_W-1:0]  s1_dm;
   logic             s1_sat;
   logic [CYC_W-1:0] s1_scaled;

   pwmdiv_range #(
      .CYC_W(CYC_W), .CNT_W(CNT_W), .PSC_W(PSC_W),
      .DIVM_MAX(DIVM_MAX), .DM_W(DM_W)
   ) u_range (
      .cycles(req_cycles),
      .div_m (s1_dm),
      .sat   (s1_sat),
      .scaled(s1_scaled)
   );

   // boundary A
   logic             a_valid, a_ready;
   logic [WA-1:0]    a_bus;
   logic             a_sat;
   logic [DM_W-1:0]  a_dm;
   logic [CYC_W-1:0] a_scaled;

   if (MID_REGS) begin : g_reg_a
      pwmdiv_slot #(.W(WA)) u_slot_a (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_valid (req_valid),
         .in_ready (req_ready),
         .in_data  ({s1_sat, s1_dm, s1_scaled}),
         .out_valid(a_valid),
         .out_ready(a_ready),
         .out_data (a_bus)
      );
   end else begin : g_wire_a
      assign a_valid   = req_valid;
      assign req_ready = a_ready;
      assign a_bus     = {s1_sat, s1_dm, s1_scaled};
   end
   assign {a_sat, a_dm, a_scaled} = a_bus;

   // stage 2: prescaler
   logic [PSC_W-1:0] s2_k;

   pwmdiv_prescale #(.CYC_W(CYC_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_prescale (
      .sat     (a_sat),
      .scaled  (a_scaled),
      .prescale(s2_k)
   );

   // boundary B
   logic             b_valid, b_ready;
   logic [WB-1:0]    b_bus;
   logic [DM_W-1:0]  b_dm;
   logic [CYC_W-1:0] b_scaled;
   logic [PSC_W-1:0] b_k;

   if (MID_REGS) begin : g_reg_b
      pwmdiv_slot #(.W(WB)) u_slot_b (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_valid (a_valid),
         .in_ready (a_ready),
         .in_data  ({a_dm, a_scaled, s2_k}),
         .out_valid(b_valid),
         .out_ready(b_ready),
         .out_data (b_bus)
      );
   end else begin : g_wire_b
      assign b_valid = a_valid;
      assign a_ready = b_ready;
      assign b_bus   = {a_dm, a_scaled, s2_k};
   end
   assign {b_dm, b_scaled, b_k} = b_bus;

   // stage 3: period count
   logic [CNT_W-1:0] s3_period;

   pwmdiv_count #(.CYC_W(CYC_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_count (
      .scaled  (b_scaled),
      .prescale(b_k),
      .period  (s3_period)
   );

   // output register, always present
   logic [WO-1:0] rsp_bus;

   pwmdiv_slot #(.W(WO)) u_slot_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (b_valid),
      .in_ready (b_ready),
      .in_data  ({b_dm, b_k, s3_period}),
      .out_valid(rsp_valid),
      .out_ready(rsp_ready),
      .out_data (rsp_bus)
   );

   assign {rsp_div_m, rsp_prescale, rsp_period} = rsp_bus;

endmodule

// File: rtl/pwm_div_solver_chk.sv
module pwm_div_solver_chk #(
   parameter int CNT_W    = 16,
   parameter int PSC_W    = 8,
   parameter int DIVM_MAX = 8,
   parameter int DM_W     = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rsp_valid,
   input logic             rsp_ready,
   input logic [DM_W-1:0]  rsp_div_m,
   input logic [PSC_W-1:0] rsp_prescale,
   input logic [CNT_W-1:0] rsp_period
);

   // R6: a stalled result keeps its fields
   a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_div_m)
                                 && $stable(rsp_prescale) && $stable(rsp_period));

   // R6: a result disappears only after it was taken
   a_r6_drop_after_take: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rsp_valid) |-> $past(rsp_ready));

   // R3: exponent capped
   a_r3_exp_cap: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> int'(rsp_div_m) <= DIVM_MAX);

   // R5: a zero period count arises only from a zero request
   a_r5_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_period == '0 |-> rsp_div_m == '0 && rsp_prescale == '0);

endmodule

bind pwm_div_solver pwm_div_solver_chk #(
   .CNT_W(CNT_W), .PSC_W(PSC_W), .DIVM_MAX(DIVM_MAX), .DM_W(DM_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rsp_valid   (rsp_valid),
   .rsp_ready   (rsp_ready),
   .rsp_div_m   (rsp_div_m),
   .rsp_prescale(rsp_prescale),
   .rsp_period  (rsp_period)
);

// File: tb/sim_pwm_div_solver.sv
`timescale 1ns/1ps
module sim_pwm_div_solver;

   localparam longint unsigned KC   = 255*65537 + 2*65536 + 1;
   localparam int              NVAL = 210;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   // u0: default, three registers
   logic        i0_v = 1'b0, i0_r, o0_v, o0_r = 1'b0;
   logic [31:0] i0_c = '0;
   logic [3:0]  o0_dm;
   logic [7:0]  o0_k;
   logic [15:0] o0_p;
   // u1: exponent cap 2, single register
   logic        i1_v = 1'b0, i1_r, o1_v, o1_r = 1'b0;
   logic [31:0] i1_c = '0;
   logic [1:0]  o1_dm;
   logic [7:0]  o1_k;
   logic [15:0] o1_p;

   pwm_div_solver u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(i0_v), .req_ready(i0_r), .req_cycles(i0_c),
      .rsp_valid(o0_v), .rsp_ready(o0_r), .rsp_div_m(o0_dm), .rsp_prescale(o0_k),
      .rsp_period(o0_p));

   pwm_div_solver #(.DIVM_MAX(2), .MID_REGS(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .req_valid(i1_v), .req_ready(i1_r), .req_cycles(i1_c),
      .rsp_valid(o1_v), .rsp_ready(o1_r), .rsp_div_m(o1_dm), .rsp_prescale(o1_k),
      .rsp_period(o1_p));

   int nchk = 0, nfail = 0;
   int idx0 = 0, idx1 = 0, acc0 = 0, acc1 = 0;
   logic [31:0] q0[$], q1[$];
   bit st0 = 0, st1 = 0;
   logic [27:0] snap0, snap1;
   logic [15:0] lf = 16'hACE1;

   function automatic logic [31:0] val_at(input int i);
      logic [31:0] h;
      if (i < 32) return 32'(64'd1 << i);
      case (i - 32)
         0: return 32'd0;
         1: return 32'd65535;
         2: return 32'd65536;
         3: return 32'd65537;
         4: return 32'd131073;
         5: return 32'd131074;
         6: return 32'(KC - 1);
         7: return 32'(KC);
         8: return 32'(2*KC - 1);
         9: return 32'(2*KC);
         10: return 32'(4*KC - 1);
         11: return 32'(4*KC);
         12: return 32'h00FF_FFFF;
         13: return 32'hFFFF_FFFF;
         default: begin
            h = 32'(i) * 32'h9E37_79B1;
            h = h ^ (h >> 13);
            return h >> (i % 29);
         end
      endcase
   endfunction

   task automatic check_bit(input string tag, input string what, input logic got, input logic exp);
      nchk++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s %s: got %0b expected %0b", tag, what, got, exp);
      end
   endtask

   task automatic check_rsp(input int dmmax, input logic [31:0] c,
                            input int dm, input int k, input int p);
      longint unsigned q, s, ek, ep;
      int f, edm;
      bit sat;
      string tag;
      q = 64'(c) / KC;
      f = 0;
      for (int i = 0; i < 64; i++) if (q[i]) f = i + 1;
      sat = f > dmmax;
      edm = sat ? dmmax : f;
      s = 64'(c) >> edm;
      if (sat) ek = 255;
      else if (s <= 65536) ek = 0;
      else ek = (s - 65536) / 65537;
      if (ek > 255) ek = 255;
      ep = s / (ek + 1);
      if (ep > 65535) ep = 65535;
      if (c == 0) tag = "R5";
      else if (sat) tag = "R3";
      else if (dm != edm) tag = "R1";
      else if (k != int'(ek)) tag = "R2";
      else tag = "R4";
      nchk++;
      if (dm != edm || k != int'(ek) || p != int'(ep)) begin
         nfail++;
         $display("FAIL %s cap=%0d cycles=%0d: got dm=%0d k=%0d per=%0d expected dm=%0d k=%0d per=%0d",
                  tag, dmmax, c, dm, k, p, edm, ek, ep);
      end
   endtask

   // one cycle of streaming traffic on both instances
   task automatic step(input bit v0, input bit r0, input bit v1, input bit r1);
      @(negedge clk);
      i0_v = v0 && (idx0 < NVAL);
      i0_c = val_at(idx0);
      o0_r = r0;
      i1_v = v1 && (idx1 < NVAL);
      i1_c = val_at(idx1);
      o1_r = r1;
      #1;
      // u0
      if (st0) begin
         nchk++;
         if (!o0_v || {o0_dm, o0_k, o0_p} !== snap0) begin
            nfail++;
            $display("FAIL R6 u0 stalled result changed: got v=%0b %h expected v=1 %h",
                     o0_v, {o0_dm, o0_k, o0_p}, snap0);
         end
      end
      if (o0_v && o0_r) begin
         if (q0.size() == 0) begin
            nchk++; nfail++;
            $display("FAIL R7 u0 unexpected result: got one expected none");
         end else check_rsp(8, q0.pop_front(), int'(o0_dm), int'(o0_k), int'(o0_p));
      end
      st0 = o0_v && !o0_r;
      snap0 = {o0_dm, o0_k, o0_p};
      if (i0_v && i0_r) begin q0.push_back(i0_c); idx0++; acc0++; end
      // u1
      if (st1) begin
         nchk++;
         if (!o1_v || {2'b00, o1_dm, o1_k, o1_p} !== snap1) begin
            nfail++;
            $display("FAIL R6 u1 stalled result changed: got v=%0b %h expected v=1 %h",
                     o1_v, {2'b00, o1_dm, o1_k, o1_p}, snap1);
         end
      end
      if (o1_v && o1_r) begin
         if (q1.size() == 0) begin
            nchk++; nfail++;
            $display("FAIL R7 u1 unexpected result: got one expected none");
         end else check_rsp(2, q1.pop_front(), int'(o1_dm), int'(o1_k), int'(o1_p));
      end
      st1 = o1_v && !o1_r;
      snap1 = {2'b00, o1_dm, o1_k, o1_p};
      if (i1_v && i1_r) begin q1.push_back(i1_c); idx1++; acc1++; end
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
   endtask

   // latency probe: one request into both, ready held high
   task automatic latency_probe(input logic [31:0] c);
      @(negedge clk);
      i0_v = 1'b1; i0_c = c; o0_r = 1'b1;
      i1_v = 1'b1; i1_c = c; o1_r = 1'b1;
      @(negedge clk);              // accepting edge passed
      i0_v = 1'b0; i1_v = 1'b0;
      check_bit("R7", "u1 valid after 1 edge", o1_v, 1'b1);
      check_rsp(2, c, int'(o1_dm), int'(o1_k), int'(o1_p));
      check_bit("R7", "u0 not valid after 1 edge", o0_v, 1'b0);
      @(negedge clk);
      check_bit("R7", "u0 not valid after 2 edges", o0_v, 1'b0);
      check_bit("R7", "u1 taken", o1_v, 1'b0);
      @(negedge clk);
      check_bit("R7", "u0 valid after 3 edges", o0_v, 1'b1);
      check_rsp(8, c, int'(o0_dm), int'(o0_k), int'(o0_p));
      @(negedge clk);
      check_bit("R7", "u0 taken", o0_v, 1'b0);
   endtask

   initial begin
      #(20.0 * 150000);
      nchk++; nfail++;
      $display("FAIL R7 watchdog expired: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      // R9: reset state
      @(negedge clk);
      @(negedge clk);
      check_bit("R9", "u0 rsp_valid in reset", o0_v, 1'b0);
      check_bit("R9", "u0 req_ready in reset", i0_r, 1'b1);
      check_bit("R9", "u1 rsp_valid in reset", o1_v, 1'b0);
      check_bit("R9", "u1 req_ready in reset", i1_r, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      check_bit("R9", "u0 rsp_valid after reset", o0_v, 1'b0);
      check_bit("R9", "u0 req_ready after reset", i0_r, 1'b1);
      check_bit("R9", "u1 rsp_valid after reset", o1_v, 1'b0);

      // R7 latency, including the R5 zero request
      latency_probe(32'd0);
      latency_probe(32'd50_000_000);

      // R8: ready low, valid high
      acc0 = 0; acc1 = 0;
      for (int n = 0; n < 6; n++) step(1'b1, 1'b0, 1'b1, 1'b0);
      nchk++;
      if (acc0 != 3) begin nfail++; $display("FAIL R8 u0 accepted: got %0d expected 3", acc0); end
      nchk++;
      if (acc1 != 1) begin nfail++; $display("FAIL R8 u1 accepted: got %0d expected 1", acc1); end
      check_bit("R8", "u0 req_ready when full", i0_r, 1'b0);
      check_bit("R8", "u1 req_ready when full", i1_r, 1'b0);

      // full throughput over powers of two and directed corners (R1-R5)
      for (int n = 0; n < 80; n++) step(1'b1, 1'b1, 1'b1, 1'b1);

      // irregular traffic with stalls (R6, R7)
      for (int n = 0; n < 4000 && (idx0 < NVAL || idx1 < NVAL); n++)
         step(lf[0], lf[3] | lf[5], lf[1], lf[4] | lf[7]);

      // drain
      for (int n = 0; n < 10; n++) step(1'b0, 1'b1, 1'b0, 1'b1);
      nchk++;
      if (q0.size() != 0 || q1.size() != 0 || idx0 != NVAL || idx1 != NVAL) begin
         nfail++;
         $display("FAIL R7 outstanding results: got %0d/%0d left, %0d/%0d sent expected 0/0 left, %0d sent",
                  q0.size(), q1.size(), idx0, idx1, NVAL);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule